// File: doc/BRIEF.md
# Integer ALU with Flag Register

This block is the integer execution unit of a small load/store processor. It takes a 32-bit first operand and a second operand that the caller picks from either a register value or an immediate value. It applies one of eight operations: add, subtract, xor, or, and, logical left shift, logical right shift and arithmetic right shift. The 32-bit result is combinational. The condition flags produced with it are captured in a 32-bit flag register.

The flag register has a fixed layout that software can read. The low four bits are the condition flags. The next two bits are an interrupt-enable bit and a user-mode bit, which belong to the rest of the processor and are never touched by an ALU operation. All higher bits are reserved and read as zero. A full-register write port lets an interrupt return path restore the saved state.

Top module: `alu_flag_unit`

## Requirements
- R1: Arithmetic. Opcode 0 adds and opcode 1 subtracts (A minus B). On add, carry is the carry out of bit 31. On subtract, carry is set when an unsigned borrow occurs (A < B). Overflow on add is set when both operands have the same sign and the result sign differs from it. Overflow on subtract is set when the operand signs differ and the result sign differs from A.
- R2: Logic. Opcode 2 is xor, opcode 3 is or and opcode 4 is and. Each of them clears carry and overflow.
- R3: Shifts. Opcode 5 shifts left logically, opcode 6 shifts right logically and opcode 7 shifts right arithmetically. Only the low 5 bits of operand B are used as the amount. Carry is the last bit shifted out, and overflow is cleared. A shift amount of 0 passes A through unchanged and clears carry.
- R4: When `useImm` is 1, operand B is `immVal`; when it is 0, operand B is `srcB`. The operation semantics are the same in both cases.
- R5: Zero is set exactly when the result is 0. Sign equals bit 31 of the result.
- R6: Flag layout: carry is bit 0, overflow bit 1, zero bit 2, sign bit 3. Bits 31 to 6 always read as zero.
- R7: An ALU operation never changes bit 4 (interrupt enable) or bit 5 (user mode).
- R8: Flags update on the clock edge that samples `opValid` high. When neither `opValid` nor `flagWrEn` is high, the register holds its value.
- R9: When `flagWrEn` is high, the next edge loads bits 5 to 0 of `flagWrData` and clears bits 31 to 6. This restore takes priority over a simultaneous `opValid`.
- R10: Reset (`rstN` low) clears the whole flag register to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Operation strobe; updates flags at the next edge |
| opCode | input | 3 | Operation select (0..7) |
| srcA | input | 32 | First operand |
| srcB | input | 32 | Register second operand |
| immVal | input | 32 | Immediate second operand |
| useImm | input | 1 | Select immediate as second operand |
| flagWrEn | input | 1 | Flag register restore strobe |
| flagWrData | input | 32 | Restore value for the flag register |
| result | output | 32 | Combinational operation result |
| flags | output | 32 | Flag register contents |

## Verification
The assertions assume that the caller's inputs are known (never X) in every cycle where `opValid` or `flagWrEn` is high. They also assume that the result seen in the cycle of a strobe is the one whose flags are captured, which means operands and opcode stay constant from the strobe cycle up to its edge. The bench drives every input on the falling clock edge and holds it for the whole cycle. It never leaves a strobe high with undriven operands. It also exercises the case where restore and operation strobes are raised together, so that the priority rule is checked.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int unsigned DataW  = 32;
  localparam int unsigned ShAmtW = $clog2(DataW);

  // flag register bit positions (software visible)
  localparam int unsigned FlgCarry = 0;
  localparam int unsigned FlgOvf   = 1;
  localparam int unsigned FlgZero  = 2;
  localparam int unsigned FlgSign  = 3;
  localparam int unsigned FlgIntEn = 4;
  localparam int unsigned FlgUser  = 5;
  localparam int unsigned FlgUsedW = 6;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_XOR = 3'd2,
    OP_OR  = 3'd3,
    OP_AND = 3'd4,
    OP_SHL = 3'd5,
    OP_SHR = 3'd6,
    OP_SRA = 3'd7
  } aluOp_e;

  typedef enum logic [1:0] {
    RES_ADDER = 2'd0,
    RES_LOGIC = 2'd1,
    RES_SHIFT = 2'd2
  } resSel_e;

  typedef enum logic [1:0] {
    LG_XOR = 2'd0,
    LG_OR  = 2'd1,
    LG_AND = 2'd2
  } logicKind_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RIGHT = 2'd1,
    SH_ARITH = 2'd2
  } shiftKind_e;

  // strobes from control to datapath / flag register
  typedef struct packed {
    logic       loadFlags;
    logic       restoreFlags;
    logic       doSub;
    resSel_e    resSel;
    logicKind_e logicKind;
    shiftKind_e shiftKind;
  } aluCtrl_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic       opValid,
  input  logic [2:0] opCode,
  input  logic       flagWrEn,
  output aluCtrl_t   ctrl
);

  aluOp_e op;
  assign op = aluOp_e'(opCode);

  always_comb begin
    ctrl              = '0;
    ctrl.restoreFlags = flagWrEn;
    ctrl.loadFlags    = opValid & ~flagWrEn;
    ctrl.doSub        = (op == OP_SUB);
    ctrl.resSel       = RES_ADDER;
    ctrl.logicKind    = LG_XOR;
    ctrl.shiftKind    = SH_LEFT;
    unique case (op)
      OP_ADD, OP_SUB: ctrl.resSel = RES_ADDER;
      OP_XOR: begin ctrl.resSel = RES_LOGIC; ctrl.logicKind = LG_XOR; end
      OP_OR:  begin ctrl.resSel = RES_LOGIC; ctrl.logicKind = LG_OR;  end
      OP_AND: begin ctrl.resSel = RES_LOGIC; ctrl.logicKind = LG_AND; end
      OP_SHL: begin ctrl.resSel = RES_SHIFT; ctrl.shiftKind = SH_LEFT;  end
      OP_SHR: begin ctrl.resSel = RES_SHIFT; ctrl.shiftKind = SH_RIGHT; end
      OP_SRA: begin ctrl.resSel = RES_SHIFT; ctrl.shiftKind = SH_ARITH; end
      default: ctrl.resSel = RES_ADDER;
    endcase
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int unsigned Width = DataW
) (
  input  aluCtrl_t           ctrl,
  input  logic [Width-1:0]   srcA,
  input  logic [Width-1:0]   srcB,
  input  logic [Width-1:0]   immVal,
  input  logic               useImm,
  output logic [Width-1:0]   result,
  output logic [3:0]         aluFlags
);

  localparam int unsigned ShW = $clog2(Width);

  logic [Width-1:0] opB;
  assign opB = useImm ? immVal : srcB;

  // shared adder: subtract via inverted operand and carry-in
  logic [Width-1:0] addB;
  logic [Width:0]   addSum;
  logic             addCarry, addOvf;
  assign addB     = ctrl.doSub ? ~opB : opB;
  assign addSum   = {1'b0, srcA} + {1'b0, addB} + {{Width{1'b0}}, ctrl.doSub};
  // for subtract the raw carry-out means "no borrow"
  assign addCarry = ctrl.doSub ? ~addSum[Width] : addSum[Width];
  assign addOvf   = (srcA[Width-1] == addB[Width-1]) &&
                    (addSum[Width-1] != srcA[Width-1]);

  logic [Width-1:0] logicRes;
  always_comb begin
    unique case (ctrl.logicKind)
      LG_OR:   logicRes = srcA | opB;
      LG_AND:  logicRes = srcA & opB;
      default: logicRes = srcA ^ opB;
    endcase
  end

  // shifter works one bit wider to expose the last bit shifted out
  logic [ShW-1:0]   shAmt;
  logic [Width:0]   shLeft, shRight, shArith;
  logic [Width-1:0] shiftRes;
  logic             shiftCarry;
  assign shAmt   = opB[ShW-1:0];
  assign shLeft  = {1'b0, srcA} << shAmt;
  assign shRight = {srcA, 1'b0} >> shAmt;
  assign shArith = $unsigned($signed({srcA, 1'b0}) >>> shAmt);

  always_comb begin
    unique case (ctrl.shiftKind)
      SH_RIGHT: begin shiftRes = shRight[Width:1]; shiftCarry = shRight[0]; end
      SH_ARITH: begin shiftRes = shArith[Width:1]; shiftCarry = shArith[0]; end
      default:  begin shiftRes = shLeft[Width-1:0]; shiftCarry = shLeft[Width]; end
    endcase
  end

  logic carry, ovf;
  always_comb begin
    unique case (ctrl.resSel)
      RES_LOGIC: begin result = logicRes; carry = 1'b0;       ovf = 1'b0;   end
      RES_SHIFT: begin result = shiftRes; carry = shiftCarry; ovf = 1'b0;   end
      default:   begin result = addSum[Width-1:0]; carry = addCarry; ovf = addOvf; end
    endcase
  end

  assign aluFlags[FlgCarry] = carry;
  assign aluFlags[FlgOvf]   = ovf;
  assign aluFlags[FlgZero]  = (result == '0);
  assign aluFlags[FlgSign]  = result[Width-1];

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_pkg::*;
#(
  parameter int unsigned Width = DataW
) (
  input  logic             clk,
  input  logic             rstN,
  input  aluCtrl_t         ctrl,
  input  logic [3:0]       aluFlags,
  input  logic [Width-1:0] wrData,
  output logic [Width-1:0] flagQ
);

  localparam logic [Width-1:0] KeepMask = Width'((1 << FlgUsedW) - 1);

  logic [Width-1:0] restoreVal, opVal;
  assign restoreVal = wrData & KeepMask;
  assign opVal      = {flagQ[Width-1:4], aluFlags};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  flagQ <= '0;
    else if (ctrl.restoreFlags) flagQ <= restoreVal;
    else if (ctrl.loadFlags)    flagQ <= opVal;
  end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic [2:0]  opCode,
  input  logic [31:0] srcA,
  input  logic [31:0] srcB,
  input  logic [31:0] immVal,
  input  logic        useImm,
  input  logic        flagWrEn,
  input  logic [31:0] flagWrData,
  output logic [31:0] result,
  output logic [31:0] flags
);

  aluCtrl_t   ctrl;
  logic [3:0] aluFlags;

  alu_ctrl u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .flagWrEn(flagWrEn),
    .ctrl    (ctrl)
  );

  alu_datapath #(.Width(DataW)) u_dp (
    .ctrl    (ctrl),
    .srcA    (srcA),
    .srcB    (srcB),
    .immVal  (immVal),
    .useImm  (useImm),
    .result  (result),
    .aluFlags(aluFlags)
  );

  alu_flag_reg #(.Width(DataW)) u_flg (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .aluFlags(aluFlags),
    .wrData  (flagWrData),
    .flagQ   (flags)
  );

endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk (
  input logic        clk,
  input logic        rstN,
  input logic        opValid,
  input logic [2:0]  opCode,
  input logic        flagWrEn,
  input logic [31:0] flagWrData,
  input logic [31:0] result,
  input logic [31:0] flags
);

  // R6
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    flags[31:6] == '0);

  // R7
  mode_bits_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !flagWrEn) |=> $stable(flags[5:4]));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!opValid && !flagWrEn) |=> $stable(flags));

  // R9
  restore_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagWrEn |=> flags == {26'b0, $past(flagWrData[5:0])});

  // R5
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !flagWrEn) |=> flags[2] == ($past(result) == 32'd0));

  // R5
  sign_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !flagWrEn) |=> flags[3] == $past(result[31]));

  // R2
  logic_clears_cv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !flagWrEn && (opCode inside {3'd2, 3'd3, 3'd4})) |=> flags[1:0] == 2'b00);

endmodule

bind alu_flag_unit alu_flag_unit_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .opValid   (opValid),
  .opCode    (opCode),
  .flagWrEn  (flagWrEn),
  .flagWrData(flagWrData),
  .result    (result),
  .flags     (flags)
);

// File: tb/alu_flag_unit_test.sv
module alu_flag_unit_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        opValid, useImm, flagWrEn;
  logic [2:0]  opCode;
  logic [31:0] srcA, srcB, immVal, flagWrData;
  logic [31:0] result, flags;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk; // 50 MHz

  alu_flag_unit uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .srcA(srcA), .srcB(srcB), .immVal(immVal), .useImm(useImm),
    .flagWrEn(flagWrEn), .flagWrData(flagWrData),
    .result(result), .flags(flags)
  );

  // {op, useImm, A, B, imm, expected result, expected flags[3:0] = S Z V C}
  localparam int NumVec = 16;
  localparam logic [135:0] VEC [NumVec] = '{
    {3'd0, 1'b0, 32'h0000_0001, 32'h0000_0002, 32'h0, 32'h0000_0003, 4'h0}, // R1 add
    {3'd0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0, 32'h0000_0000, 4'h5}, // R1 carry out
    {3'd0, 1'b0, 32'h7FFF_FFFF, 32'h0000_0001, 32'h0, 32'h8000_0000, 4'hA}, // R1 overflow
    {3'd1, 1'b0, 32'h0000_0005, 32'h0000_0005, 32'h0, 32'h0000_0000, 4'h4}, // R1 sub zero
    {3'd1, 1'b0, 32'h0000_0003, 32'h0000_0005, 32'h0, 32'hFFFF_FFFE, 4'h9}, // R1 borrow
    {3'd1, 1'b0, 32'h8000_0000, 32'h0000_0001, 32'h0, 32'h7FFF_FFFF, 4'h2}, // R1 sub ovf
    {3'd2, 1'b0, 32'hF0F0_F0F0, 32'hFFFF_FFFF, 32'h0, 32'h0F0F_0F0F, 4'h0}, // R2 xor
    {3'd3, 1'b0, 32'h0000_0000, 32'h0000_0000, 32'h0, 32'h0000_0000, 4'h4}, // R2 or
    {3'd4, 1'b0, 32'h8000_0001, 32'h8000_0000, 32'h0, 32'h8000_0000, 4'h8}, // R2 and
    {3'd5, 1'b0, 32'h8000_0001, 32'h0000_0001, 32'h0, 32'h0000_0002, 4'h1}, // R3 shl
    {3'd6, 1'b0, 32'h0000_0003, 32'h0000_0001, 32'h0, 32'h0000_0001, 4'h1}, // R3 shr
    {3'd7, 1'b0, 32'h8000_0000, 32'h0000_0004, 32'h0, 32'hF800_0000, 4'h8}, // R3 sra
    {3'd5, 1'b1, 32'h0000_0001, 32'h0000_0007, 32'h21, 32'h0000_0002, 4'h0}, // R3 amount 33 -> 1
    {3'd6, 1'b0, 32'h8000_0000, 32'h0000_0000, 32'h0, 32'h8000_0000, 4'h8}, // R3 amount 0
    {3'd0, 1'b1, 32'h0000_000A, 32'h0000_FFFF, 32'h5, 32'h0000_000F, 4'h0}, // R4 immediate
    {3'd7, 1'b0, 32'h8000_0000, 32'h0000_001F, 32'h0, 32'hFFFF_FFFF, 4'h8}  // R3 sra by 31
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic idleInputs();
    opValid = 1'b0; flagWrEn = 1'b0; useImm = 1'b0; opCode = 3'd0;
    srcA = '0; srcB = '0; immVal = '0; flagWrData = '0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idleInputs();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R10 reset flags", flags, 32'h0);
    @(negedge clk) rstN = 1'b1;

    // R9: restore with reserved bits set; only low six survive
    @(negedge clk); flagWrEn = 1'b1; flagWrData = 32'hFFFF_FFF0;
    @(posedge clk); #2;
    check("R9 restore mask", flags, 32'h0000_0030);
    @(negedge clk); flagWrEn = 1'b0;

    // table walk with mode bits 5:4 set beforehand (R7)
    for (int i = 0; i < NumVec; i++) begin
      logic [135:0] v;
      v = VEC[i];
      @(negedge clk);
      opValid = 1'b1;
      opCode  = v[135:133];
      useImm  = v[132];
      srcA    = v[131:100];
      srcB    = v[99:68];
      immVal  = v[67:36];
      #2;
      check($sformatf("R1-R4 vector %0d result", i), result, v[35:4]);
      @(posedge clk); #2;
      check($sformatf("R5 R6 R7 vector %0d flags", i), flags, {26'b0, 2'b11, v[3:0]});
    end

    // R8: idle holds flags while inputs change
    @(negedge clk);
    opValid = 1'b0; opCode = 3'd1; srcA = 32'h1; srcB = 32'h2;
    repeat (2) @(posedge clk);
    #2;
    check("R8 idle hold", flags, 32'h0000_0038);

    // R9: restore beats a simultaneous operation
    @(negedge clk);
    opValid = 1'b1; opCode = 3'd0; srcA = 32'h0; srcB = 32'h0;
    flagWrEn = 1'b1; flagWrData = 32'h0000_0011;
    @(posedge clk); #2;
    check("R9 restore priority", flags, 32'h0000_0011);

    // R7 with mode bits clear: op producing carry leaves bits 5:4 as 01
    @(negedge clk);
    flagWrEn = 1'b0; opValid = 1'b1; opCode = 3'd5; srcA = 32'h8000_0000; srcB = 32'h1;
    @(posedge clk); #2;
    check("R7 R3 mode kept", flags, 32'h0000_0015);

    // R10: asynchronous reset mid-run
    @(negedge clk);
    idleInputs();
    rstN = 1'b0;
    #2;
    check("R10 async reset", flags, 32'h0);
    @(negedge clk) rstN = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule